// File: doc/BRIEF.md
# Shutdown Request Input Qualifier

This block watches an active-low external shutdown pin and decides when a real request has arrived. It brings the pin into the clock domain through a two-flop synchronizer. It then qualifies the pin in one of four ways, chosen by a 2-bit mode field. The qualified result sets a sticky request flag, which the rest of the chip uses to force its outputs into a safe state.

In the edge mode, a single high-to-low transition of the synchronized pin is enough. In the three filtered modes, the pin is sampled on single-cycle ticks that a free-running prescaler derives from the peripheral clock, at one of three division ratios. A request is taken only after 16 consecutive low samples. A single high sample restarts the count.

The mode field can be written only once after reset, so a runaway program cannot weaken the filter later. Software clears the flag with a read-then-write handshake: it must read the flag as 1 before a clear strobe takes effect.

Top module: `sdq_qualifier`

## Requirements
- R1: After reset, `mode_q` reads 2'b00 and `req_flag` reads 0. With the pin held high, the flag stays 0.
- R2: In mode 2'b00 (edge), a falling pin sets `req_flag`. The flag is still 0 two rising edges after the pin falls and is 1 after the third rising edge, because the pin passes through two synchronizer flops first.
- R3: In mode 2'b01, the flag sets once 16 consecutive samples taken every 8 clock cycles are all low. It is 0 at 120 cycles and 1 at 140 cycles after the pin falls.
- R4: In mode 2'b10, samples are taken every 16 cycles. The flag is 0 at 240 cycles and 1 at 276 cycles after the pin falls.
- R5: In mode 2'b11, samples are taken every 128 cycles. The flag is 0 at 1920 cycles and 1 at 2180 cycles after the pin falls.
- R6: Any high sample in a filtered mode restarts the low count from zero. A low pulse shorter than 16 samples never sets the flag.
- R7: Only the first `mode_we` write after reset changes `mode_q`. Every later write is ignored.
- R8: A `flag_clr` strobe has no effect unless `req_flag` was read as 1 through a `flag_rd` strobe beforehand.
- R9: A `flag_clr` strobe that follows such a read clears `req_flag` on the next edge.
- R10: When a set condition and a valid clear fall in the same cycle, the set wins and `req_flag` stays 1. The read from before that cycle still counts for a later clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| pin_n | input | 1 | Asynchronous active-low shutdown pin |
| mode_we | input | 1 | Mode write strobe |
| mode_wdata | input | 2 | Mode value to write |
| flag_rd | input | 1 | Flag read strobe; arms the clear when the flag is 1 |
| flag_clr | input | 1 | Write-zero strobe for the flag |
| mode_q | output | 2 | Current qualification mode |
| req_flag | output | 1 | Sticky shutdown request flag |

## Verification
The edge mode is driven with a clean fall and probed one cycle before and one cycle after the edge on which it must appear. This separates a correct two-stage synchronizer from a shorter or longer path. Each filtered mode is driven with a sustained low level and probed just before the earliest and just after the latest possible acceptance time, which tells the three division ratios apart. A low-high-low pattern and a short low pulse show whether a high sample truly restarts the count. Clear strobes are issued without a read, after a read, and in the same cycle as a new falling edge, which separates the handshake from the set-over-clear priority.

// File: rtl/sdq_pkg.sv
package sdq_pkg;
  typedef enum logic [1:0] {
    QM_EDGE  = 2'b00,
    QM_DIV_A = 2'b01,
    QM_DIV_B = 2'b10,
    QM_DIV_C = 2'b11
  } qual_mode_e;
endpackage

// File: rtl/sdq_sync.sv
module sdq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/sdq_prescaler.sv
module sdq_prescaler #(
  parameter int DIV_A_LOG2 = 3,
  parameter int DIV_B_LOG2 = 4,
  parameter int DIV_C_LOG2 = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic [2:0] tick
);
  localparam int PRE_W = DIV_C_LOG2;

  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // Each tick fires on the last count of its own power-of-two period.
  for (genvar i = 0; i < 3; i++) begin : g_tick
    localparam int L = (i == 0) ? DIV_A_LOG2 : (i == 1) ? DIV_B_LOG2 : DIV_C_LOG2;
    assign tick[i] = &cnt_q[L-1:0];
  end
endmodule

// File: rtl/sdq_filter.sv
module sdq_filter
  import sdq_pkg::*;
#(
  parameter int SAMPLES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_s,
  input  qual_mode_e mode,
  input  logic [2:0] tick,
  output logic       hit
);
  localparam int CNT_W = $clog2(SAMPLES + 1);

  logic             prev_q;
  logic             fall;
  logic             sel_tick;
  logic             cnt_en;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    case (mode)
      QM_DIV_A: sel_tick = tick[0];
      QM_DIV_B: sel_tick = tick[1];
      QM_DIV_C: sel_tick = tick[2];
      default:  sel_tick = 1'b0;
    endcase
  end

  assign fall = prev_q & ~pin_s;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (mode == QM_EDGE) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (sel_tick) begin
      cnt_en = 1'b1;
      if (pin_s)                                 cnt_d = '0;
      else if (cnt_q != CNT_W'(SAMPLES))         cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_comb begin
    if (mode == QM_EDGE) hit = fall;
    else                 hit = sel_tick & ~pin_s & (cnt_q == CNT_W'(SAMPLES - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= pin_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sdq_qualifier.sv
module sdq_qualifier
  import sdq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SAMPLES     = 16,
  parameter int DIV_A_LOG2  = 3,
  parameter int DIV_B_LOG2  = 4,
  parameter int DIV_C_LOG2  = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_n,
  input  logic       mode_we,
  input  logic [1:0] mode_wdata,
  input  logic       flag_rd,
  input  logic       flag_clr,
  output logic [1:0] mode_q,
  output logic       req_flag
);
  logic       pin_s;
  logic [2:0] tick_w;
  logic       hit_w;

  logic       lock_q,  lock_d;
  logic [1:0] mode_d;
  logic       flag_q,  flag_d;
  logic       armed_q, armed_d;
  logic       cfg_en;

  sdq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_n), .q(pin_s)
  );

  sdq_prescaler #(
    .DIV_A_LOG2(DIV_A_LOG2), .DIV_B_LOG2(DIV_B_LOG2), .DIV_C_LOG2(DIV_C_LOG2)
  ) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(tick_w)
  );

  sdq_filter #(.SAMPLES(SAMPLES)) u_filt (
    .clk(clk), .rst_n(rst_n), .pin_s(pin_s),
    .mode(qual_mode_e'(mode_q)), .tick(tick_w), .hit(hit_w)
  );

  // Mode register: first write wins, then the lock bit freezes it.
  always_comb begin
    cfg_en = mode_we & ~lock_q;
    mode_d = mode_wdata;
    lock_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 2'b00;
      lock_q <= 1'b0;
    end else if (cfg_en) begin
      mode_q <= mode_d;
      lock_q <= lock_d;
    end
  end

  // Sticky flag with read-then-clear handshake; a set beats a clear.
  always_comb begin
    flag_d  = flag_q;
    armed_d = armed_q | (flag_rd & flag_q);
    if (hit_w) begin
      flag_d = 1'b1;
    end else if (flag_clr && armed_q) begin
      flag_d  = 1'b0;
      armed_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      flag_q  <= flag_d;
      armed_q <= armed_d;
    end
  end

  assign req_flag = flag_q;
endmodule

// File: rtl/sdq_checker.sv
module sdq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_q,
  input logic       req_flag,
  input logic       flag_clr,
  input logic [2:0] tick,
  input logic       hit
);
  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != 2'b00) |=> $stable(mode_q)); // R7

  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_flag && !flag_clr) |=> req_flag); // R8

  AST_CLEAR_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_flag) |-> $past(flag_clr)); // R9

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> req_flag); // R10

  AST_TICK_NESTED: assert property (@(posedge clk) disable iff (!rst_n)
    tick[2] |-> (tick[1] && tick[0])); // R5

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick[0] |=> !tick[0]); // R3
endmodule

bind sdq_qualifier sdq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .req_flag(req_flag),
  .flag_clr(flag_clr), .tick(tick_w), .hit(hit_w)
);

// File: tb/tb_sdq_qualifier.sv
module tb_sdq_qualifier;
  logic       clk;
  logic       rst_n;
  logic       pin_n;
  logic       mode_we;
  logic [1:0] mode_wdata;
  logic       flag_rd;
  logic       flag_clr;
  logic [1:0] mode_q;
  logic       req_flag;

  int checks;
  int errors;
  bit done;

  sdq_qualifier dut (
    .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .mode_we(mode_we),
    .mode_wdata(mode_wdata), .flag_rd(flag_rd), .flag_clr(flag_clr),
    .mode_q(mode_q), .req_flag(req_flag)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; pin_n = 1'b1; mode_we = 1'b0; mode_wdata = 2'b00;
    flag_rd = 1'b0; flag_clr = 1'b0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
  endtask

  task automatic set_mode(input logic [1:0] m);
    mode_we = 1'b1; mode_wdata = m;
    @(negedge clk);
    mode_we = 1'b0;
  endtask

  task automatic do_read();
    flag_rd = 1'b1;
    @(negedge clk);
    flag_rd = 1'b0;
  endtask

  task automatic do_clear();
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    check("R1 mode after reset", mode_q, 0);
    check("R1 flag after reset", req_flag, 0);
    wait_cyc(300);
    check("R1 flag idle with pin high", req_flag, 0);
  endtask

  task automatic t_edge_and_clear();
    do_reset();
    set_mode(2'b00);
    pin_n = 1'b0;
    wait_cyc(2);
    check("R2 flag before third edge", req_flag, 0);
    wait_cyc(1);
    check("R2 flag after third edge", req_flag, 1);
    pin_n = 1'b1;
    wait_cyc(4);
    do_clear();
    wait_cyc(1);
    check("R8 clear without read ignored", req_flag, 1);
    do_read();
    do_clear();
    check("R9 read then clear", req_flag, 0);
  endtask

  task automatic t_set_beats_clear();
    do_reset();
    set_mode(2'b00);
    pin_n = 1'b0;
    wait_cyc(4);
    pin_n = 1'b1;
    wait_cyc(4);
    do_read();
    pin_n = 1'b0;
    wait_cyc(2);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    check("R10 set wins over clear", req_flag, 1);
    pin_n = 1'b1;
    wait_cyc(4);
    do_clear();
    check("R10 earlier read still arms clear", req_flag, 0);
  endtask

  task automatic t_filter(input logic [1:0] m, input int early, input int late,
                          input string req);
    do_reset();
    set_mode(m);
    pin_n = 1'b0;
    wait_cyc(early);
    check({req, " flag not yet set"}, req_flag, 0);
    wait_cyc(late - early);
    check({req, " flag set after 16 low samples"}, req_flag, 1);
    pin_n = 1'b1;
  endtask

  task automatic t_write_once();
    do_reset();
    set_mode(2'b10);
    check("R7 first write taken", mode_q, 2);
    set_mode(2'b01);
    check("R7 second write ignored", mode_q, 2);
    set_mode(2'b00);
    check("R7 third write ignored", mode_q, 2);
  endtask

  task automatic t_restart();
    do_reset();
    set_mode(2'b01);
    pin_n = 1'b0;
    wait_cyc(80);
    pin_n = 1'b1;
    wait_cyc(24);
    pin_n = 1'b0;
    wait_cyc(100);
    check("R6 count restarted by high sample", req_flag, 0);
    wait_cyc(40);
    check("R6 flag set after fresh 16 lows", req_flag, 1);
    do_reset();
    set_mode(2'b10);
    pin_n = 1'b0;
    wait_cyc(200);
    pin_n = 1'b1;
    wait_cyc(400);
    check("R6 short low pulse rejected", req_flag, 0);
  endtask

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; pin_n = 1'b1; mode_we = 1'b0; mode_wdata = 2'b00;
    flag_rd = 1'b0; flag_clr = 1'b0;
    t_reset_state();
    t_edge_and_clear();
    t_set_beats_clear();
    t_filter(2'b01, 120, 140, "R3");
    t_filter(2'b10, 240, 276, "R4");
    t_filter(2'b11, 1920, 2180, "R5");
    t_write_once();
    t_restart();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule